// File: doc/BRIEF.md
# Accumulator CPU Control Path

This block sequences instructions for a small 8-bit accumulator processor whose program and data share one memory. It keeps a 6-bit program counter and an 8-bit instruction register. It also drives the memory address. It tells the accumulator and ALU outside it when to load and which operation to apply. Each instruction byte packs a 2-bit operation code in bits 7:6 and a 6-bit memory address in bits 5:0. An address multiplexer puts the program counter on the bus while an instruction is being read. It puts the instruction's address field on the bus while data is read or written.

Every instruction takes three clock cycles. The first is a fetch cycle: the word at the program counter is read, latched into the instruction register, and the counter steps forward. The second is a decode cycle with no strobes. The third is an execute or store cycle. In that cycle the block reads an operand for the ALU, writes the accumulator out, or resolves a jump that is taken when the accumulator's carry flag is clear. Memory reads are combinational: the data bus reflects the address in the same cycle.

Top module: `acc_ctrl_path`

## Requirements
- R1: A synchronous active-high reset `rst` returns the block to the fetch cycle with the program counter at 0. In the first cycle after reset, `mem_addr` is 0, `mem_rd` is 1, and `mem_wr` and `acc_load` are 0. This holds even when reset arrives in the middle of an instruction.
- R2: In a fetch cycle `mem_addr` equals the program counter and `mem_rd` is 1. At the end of that cycle the program counter advances by one, and from 63 it wraps to 0.
- R3: The word on `mem_rdata` at the end of a fetch cycle is held as the current instruction. `opcode` shows its bits 7:6 and the address field is its bits 5:0. `opcode` does not change during the decode and execute cycles, even when `mem_rdata` changes.
- R4: The cycle after every fetch is a decode cycle. In it `mem_addr` equals the address field and `mem_rd`, `mem_wr` and `acc_load` are 0.
- R5: For opcode 00 (NOR memory into accumulator) and 01 (ADD memory to accumulator), the third cycle has `mem_rd` = 1, `acc_load` = 1, `mem_wr` = 0 and `mem_addr` equal to the address field. In that cycle `alu_add` is 0 for opcode 00 and 1 for opcode 01.
- R6: For opcode 10 (store accumulator), the third cycle has `mem_wr` = 1, `mem_rd` = 0, `acc_load` = 0 and `mem_addr` equal to the address field.
- R7: For opcode 11 (jump if carry clear), the third cycle has no strobes. If `acc_carry` is 0 during that cycle, the next fetch is from the address field. Otherwise it is from the instruction's own address plus one. Loading the jump target takes priority over incrementing the counter.
- R8: Every instruction occupies exactly three cycles, so fetches come every third cycle, and `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 8 | Combinational read data from memory |
| acc_carry | input | 1 | Carry flag of the accumulator |
| mem_addr | output | 6 | Memory address (program counter or instruction address field) |
| opcode | output | 2 | Operation code of the held instruction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (accumulator to memory) |
| acc_load | output | 1 | Accumulator load enable |
| alu_add | output | 1 | ALU select: 1 = add, 0 = NOR |

## Verification
The hardest case to reach from the ports is the program counter wrapping from 63 to 0. Reaching it by straight-line fetches would need 64 instructions. Instead, the stimulus places a jump to 63 at address 0 with the carry held low, puts an ADD at 63, and checks that the next fetch is from address 0. The carry is also changed between the decode and execute cycles of a jump, to show that the decision uses the flag's value in the execute cycle. A reset is also applied during a store cycle, to show that it cuts the instruction short.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int CP_ADDR_W = 6;
    localparam int CP_OP_W   = 2;
    localparam int CP_WORD_W = CP_OP_W + CP_ADDR_W;

    typedef logic [CP_ADDR_W-1:0] addr_t;
    typedef logic [CP_WORD_W-1:0] word_t;

    typedef enum logic [CP_OP_W-1:0] {
        OP_NOR   = 2'b00,
        OP_ADD   = 2'b01,
        OP_STORE = 2'b10,
        OP_JNC   = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_STORE  = 2'd3
    } phase_e;

    // Operation code sits in the upper bits of the word.
    typedef struct packed {
        opcode_e op;
        addr_t   operand;
    } instr_t;

    typedef struct packed {
        logic ir_load;
        logic pc_inc;
        logic pc_load;
        logic sel_operand;
        logic mem_rd;
        logic mem_wr;
        logic acc_load;
        logic alu_add;
    } ctrl_t;

    function automatic instr_t split_word(word_t w);
        return instr_t'(w);
    endfunction

    function automatic phase_e next_phase(phase_e ph, opcode_e op);
        phase_e n;
        case (ph)
            PH_FETCH:  n = PH_DECODE;
            PH_DECODE: n = (op == OP_STORE) ? PH_STORE : PH_EXEC;
            default:   n = PH_FETCH;
        endcase
        return n;
    endfunction

    function automatic ctrl_t phase_ctrl(phase_e ph, opcode_e op, logic carry);
        ctrl_t c;
        c = '0;
        case (ph)
            PH_FETCH: begin
                c.mem_rd  = 1'b1;
                c.ir_load = 1'b1;
                c.pc_inc  = 1'b1;
            end
            PH_DECODE: begin
                c.sel_operand = 1'b1;
            end
            PH_EXEC: begin
                c.sel_operand = 1'b1;
                case (op)
                    OP_NOR: begin
                        c.mem_rd   = 1'b1;
                        c.acc_load = 1'b1;
                    end
                    OP_ADD: begin
                        c.mem_rd   = 1'b1;
                        c.acc_load = 1'b1;
                        c.alu_add  = 1'b1;
                    end
                    OP_JNC: begin
                        c.pc_load = ~carry;
                    end
                    default: ;
                endcase
            end
            PH_STORE: begin
                c.sel_operand = 1'b1;
                c.mem_wr      = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_pc.sv
module acc_pc #(
    parameter int W = acc_cpu_pkg::CP_ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] pc
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load)
            pc_q <= load_val;
        else if (inc)
            pc_q <= pc_q + ONE;
    end

    assign pc = pc_q;

    // R2: single step with modulo wrap
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (pc_q == W'($past(pc_q) + ONE)));

    // R7: jump target wins over increment
    a_r7_load_priority: assert property (@(posedge clk) disable iff (rst)
        load |=> (pc_q == $past(load_val)));

    a_r2_pc_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(pc_q));

endmodule

// File: rtl/acc_ir.sv
module acc_ir
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  word_t  word,
    output instr_t instr
);

    instr_t ir_q;

    always_ff @(posedge clk) begin
        if (rst)
            ir_q <= '0;
        else if (load)
            ir_q <= split_word(word);
    end

    assign instr = ir_q;

    // R3: captured word and held value
    a_r3_ir_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (word_t'(ir_q) == $past(word)));

    a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ir_q));

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    carry,
    output phase_e  phase,
    output ctrl_t   ctrl
);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_FETCH;
        else
            ph_q <= next_phase(ph_q, op);
    end

    assign phase = ph_q;

    always_comb begin
        ctrl = phase_ctrl(ph_q, op, carry);
    end

    // R4: decode always follows fetch
    a_r4_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FETCH) |=> (ph_q == PH_DECODE));

    // R6: store phase only entered from decode of a store
    a_r6_store_entry: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_STORE) |-> ($past(ph_q) == PH_DECODE && op == OP_STORE));

    // R8: third cycle always returns to fetch
    a_r8_three_cycles: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_EXEC || ph_q == PH_STORE) |=> (ph_q == PH_FETCH));

    // R8: read and write strobes exclusive
    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_rd && ctrl.mem_wr));

    // R7: jump load only in execute of a jump
    a_r7_load_in_exec: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_load |-> (ph_q == PH_EXEC && op == OP_JNC && !carry));

endmodule

// File: rtl/acc_ctrl_path.sv
module acc_ctrl_path
    import acc_cpu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CP_WORD_W-1:0] mem_rdata,
    input  logic                 acc_carry,
    output logic [CP_ADDR_W-1:0] mem_addr,
    output logic [CP_OP_W-1:0]   opcode,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 acc_load,
    output logic                 alu_add
);

    instr_t ir;
    addr_t  pc;
    phase_e phase;
    ctrl_t  ctrl;

    acc_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .op    (ir.op),
        .carry (acc_carry),
        .phase (phase),
        .ctrl  (ctrl)
    );

    acc_ir u_ir (
        .clk   (clk),
        .rst   (rst),
        .load  (ctrl.ir_load),
        .word  (mem_rdata),
        .instr (ir)
    );

    acc_pc #(.W(CP_ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .inc      (ctrl.pc_inc),
        .load     (ctrl.pc_load),
        .load_val (ir.operand),
        .pc       (pc)
    );

    // Address bus source: program counter for fetch, operand field otherwise.
    assign mem_addr = ctrl.sel_operand ? ir.operand : pc;
    assign opcode   = ir.op;
    assign mem_rd   = ctrl.mem_rd;
    assign mem_wr   = ctrl.mem_wr;
    assign acc_load = ctrl.acc_load;
    assign alu_add  = ctrl.alu_add;

    // R2: fetch cycles read
    a_r2_fetch_reads: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> (mem_rd && !mem_wr && !acc_load));

    // R5: accumulator loads only with a read
    a_r5_load_with_read: assert property (@(posedge clk) disable iff (rst)
        acc_load |-> (mem_rd && phase == PH_EXEC));

endmodule

// File: tb/sim_acc_ctrl_path.sv
module sim_acc_ctrl_path;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_rdata;
    logic       acc_carry = 1'b0;
    logic [5:0] mem_addr;
    logic [1:0] opcode;
    logic       mem_rd, mem_wr, acc_load, alu_add;

    logic [7:0] mem [64];

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    acc_ctrl_path u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .acc_carry (acc_carry),
        .mem_addr  (mem_addr),
        .opcode    (opcode),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .acc_load  (acc_load),
        .alu_add   (alu_add)
    );

    // {instruction, carry during execute}
    localparam logic [8:0] VECS [0:7] = '{
        {8'b00_000101, 1'b0},
        {8'b01_111111, 1'b1},
        {8'b10_101010, 1'b0},
        {8'b11_010000, 1'b0},
        {8'b11_010000, 1'b1},
        {8'b01_000000, 1'b0},
        {8'b10_000000, 1'b1},
        {8'b11_111111, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_mem();
        #1;
        do_reset();

        // R1 reset state
        check("R1 addr", mem_addr, 0);
        check("R1 rd", mem_rd, 1);
        check("R1 wr", mem_wr, 0);
        check("R1 acc_load", acc_load, 0);

        // Vector table: one instruction per entry
        for (int v = 0; v < 8; v++) begin
            logic [7:0] ins;
            logic [1:0] op;
            logic [5:0] fld;
            logic       cy;
            int         nxt;
            ins = VECS[v][8:1];
            cy  = VECS[v][0];
            op  = ins[7:6];
            fld = ins[5:0];
            clear_mem();
            mem[fld] = 8'h5A ^ 8'(v);
            mem[0]   = ins;
            acc_carry = cy;
            do_reset();
            check("R2 fetch addr", mem_addr, 0);
            check("R2 fetch rd", mem_rd, 1);
            step();
            check("R3 opcode", opcode, op);
            check("R4 decode addr", mem_addr, fld);
            check("R4 decode strobes", {mem_rd, mem_wr, acc_load}, 0);
            step();
            check("R3 opcode held", opcode, op);
            check("R5 R6 exec addr", mem_addr, fld);
            case (op)
                2'b00, 2'b01: begin
                    check("R5 rd", mem_rd, 1);
                    check("R5 acc_load", acc_load, 1);
                    check("R5 wr", mem_wr, 0);
                    check("R5 alu_add", alu_add, (op == 2'b01) ? 1 : 0);
                end
                2'b10: begin
                    check("R6 wr", mem_wr, 1);
                    check("R6 rd", mem_rd, 0);
                    check("R6 acc_load", acc_load, 0);
                end
                default: begin
                    check("R7 strobes", {mem_rd, mem_wr, acc_load}, 0);
                end
            endcase
            nxt = (op == 2'b11 && !cy) ? int'(fld) : 1;
            step();
            check("R7 R8 next fetch addr", mem_addr, nxt);
            check("R8 next fetch rd", mem_rd, 1);
        end

        // R2 wrap: jump to 63, then fall through to 0
        clear_mem();
        mem[0]  = 8'hFF;
        mem[63] = 8'h41;
        acc_carry = 1'b0;
        do_reset();
        repeat (3) step();
        check("R7 jump to 63", mem_addr, 63);
        repeat (3) step();
        check("R2 wrap 63 to 0", mem_addr, 0);

        // R7 carry sampled in execute cycle, not decode
        clear_mem();
        mem[0] = 8'b11_001001;
        acc_carry = 1'b1;
        do_reset();
        step();
        step();
        acc_carry = 1'b0;
        step();
        check("R7 carry at execute", mem_addr, 9);

        // R1 reset during store cycle
        clear_mem();
        mem[0] = 8'b10_000101;
        mem[1] = 8'b01_000111;
        do_reset();
        step();
        step();
        check("R6 store cycle wr", mem_wr, 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 mid reset addr", mem_addr, 0);
        check("R1 mid reset wr", mem_wr, 0);
        check("R1 mid reset rd", mem_rd, 1);

        // R8 straight-line program: fetch every third cycle, rd/wr exclusive
        clear_mem();
        mem[0] = 8'b01_001010;
        mem[1] = 8'b10_001011;
        mem[2] = 8'b00_001100;
        acc_carry = 1'b1;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            check("R8 fetch addr", mem_addr, k);
            for (int c = 0; c < 3; c++) begin
                check("R8 rd wr exclusive", mem_rd & mem_wr, 0);
                step();
            end
        end
        check("R8 fourth fetch addr", mem_addr, 3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule